// File: doc/BRIEF.md
# DRAM Refresh and Initialisation Sequencer

This block brings an asynchronous DRAM out of power-up and then keeps its contents alive. After reset it stays quiet for a fixed pause, which gives the device time to settle its internal bias. It then runs a burst of refresh-type wake-up cycles. Once these are complete it declares the memory ready. From then on it raises one refresh request per fixed interval, so that every row is refreshed within the retention period.

The block owns the row strobe, column strobe, write enable and address lines only while the access controller has granted them. Arbitration is a plain request/grant handshake. Requests that arrive while the controller is busy are counted, so none is lost. A flag is raised when the backlog grows beyond a set limit. A parameter selects the kind of refresh cycle:

- **Column-first mode:** the column strobe falls before the row strobe, and the device's own row counter picks the row.
- **Row-only mode:** the column strobe stays high, and the row address comes from a counter inside this block.

The sequencer is a Moore machine with six states:

- **PAUSE:** the power-up wait.
- **IDLE:** nothing is owed.
- **REQ:** requesting the lines.
- **SETUP:** the column strobe is low, or the row address is set up.
- **ACTIVE:** the row strobe is low.
- **PRECH:** both strobes are high for precharge.

Its transitions are:

- PAUSE to REQ when the pause expires.
- IDLE to REQ when the backlog is non-zero.
- REQ to SETUP on grant.
- SETUP to ACTIVE, and ACTIVE to PRECH, when each phase count expires.
- PRECH to REQ while wake-up cycles remain.
- PRECH to IDLE otherwise.

Top module: `dram_rfsh_seq`

## Requirements
- R1: While reset is held and in the first cycle after it, both strobes and write enable are high (inactive), addr_o is zero, and rfsh_req_o, bus_own_o, ready_o and backlog_hi_o are low.
- R2: rfsh_req_o first goes high exactly PAUSE_CYC clock edges after reset is released. No strobe moves before then.
- R3: Exactly INIT_CYCLES refresh cycles run back to back before ready_o rises. ready_o rises on the edge that ends the precharge of the last of them, and never falls until reset.
- R4: Starting from the rise of ready_o, one refresh is owed every INTERVAL_CYC clocks. The first is owed INTERVAL_CYC clocks after ready_o rises.
- R5: rfsh_req_o stays high while rfsh_grant_i is low. The clock edge that samples the grant high starts the cycle, and bus_own_o goes high. Outside bus_own_o, all strobes are inactive and addr_o is zero.
- R6: In column-first mode (MODE = RFM_CAS_FIRST), cas_n_o is low for T_SETUP clocks before ras_n_o falls. Both strobes are then low for T_ACTIVE clocks, and both are high for T_PRECH clocks of precharge.
- R7: we_n_o is high in every cycle, so the device never sees the write enable low around a row-strobe fall.
- R8: In row-only mode (MODE = RFM_ROW_ONLY), cas_n_o stays high throughout. During ownership, addr_o carries the row counter in bits ROW_W-1:0, and its top bit is 0. ras_n_o is high for T_SETUP clocks of address setup, low for T_ACTIVE clocks, and high for T_PRECH clocks.
- R9: The row counter starts at zero and advances by one on the edge that ends each ACTIVE phase. It wraps from all ones to zero.
- R10: After ready, the backlog counts owed refreshes minus completed ones. The counter is $clog2(BACKLOG_MAX+1)+1 bits wide and saturates at all ones. While the backlog is non-zero, the block requests again after passing through IDLE.
- R11: backlog_hi_o is high exactly while the backlog exceeds BACKLOG_MAX.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rfsh_grant_i | input | 1 | Access controller hands the DRAM lines to this block |
| rfsh_req_o | output | 1 | Request for the DRAM lines |
| bus_own_o | output | 1 | Block is driving the DRAM lines |
| ready_o | output | 1 | Wake-up done; normal accesses allowed |
| backlog_hi_o | output | 1 | Owed refreshes exceed BACKLOG_MAX |
| ras_n_o | output | 1 | Row strobe, active low |
| cas_n_o | output | 1 | Column strobe, active low |
| we_n_o | output | 1 | Write enable, active low |
| addr_o | output | ROW_W+1 | Multiplexed address (row-only refresh row) |

## Verification
The bench instantiates the block twice, once in column-first mode and once in row-only mode. Both instances use PAUSE_CYC=20, INTERVAL_CYC=40, INIT_CYCLES=8, T_SETUP=2, T_ACTIVE=4, T_PRECH=3, BACKLOG_MAX=3 and ROW_W=4.

These short values put the pause edge, the end of wake-up and many periodic refreshes within a few hundred clocks. A 200-clock grant blackout pushes the backlog past its limit. The 16-row counter wraps several times during the run. A stretch of intermittent grant exercises request holding and the back-to-back draining of the backlog.

// File: rtl/dram_rfsh_pkg.sv
package dram_rfsh_pkg;
    typedef enum logic [0:0] {
        RFM_CAS_FIRST = 1'b0,
        RFM_ROW_ONLY  = 1'b1
    } rfsh_mode_e;

    typedef enum logic [2:0] {
        ST_PAUSE,
        ST_IDLE,
        ST_REQ,
        ST_SETUP,
        ST_ACTIVE,
        ST_PRECH
    } seq_state_e;
endpackage

// File: rtl/rfsh_interval_gen.sv
module rfsh_interval_gen #(
    parameter int INTERVAL_CYC = 1560,
    parameter int BACKLOG_MAX  = 8,
    parameter int PEND_W       = 5
) (
    input  logic clk,
    input  logic rst_n,
    input  logic en,
    input  logic served,
    output logic pending_nz,
    output logic backlog_hi
);
    localparam int CNT_W = $clog2(INTERVAL_CYC + 1);

    logic [CNT_W-1:0]  ivl_q;
    logic [PEND_W-1:0] pend_q;
    logic              tick;

    assign tick = en && (ivl_q == CNT_W'(INTERVAL_CYC - 1));

    always_ff @(posedge clk) begin
        if (!rst_n || !en) begin
            ivl_q <= '0;
        end else if (tick) begin
            ivl_q <= '0;
        end else begin
            ivl_q <= ivl_q + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend_q <= '0;
        end else begin
            unique case ({tick, served})
                2'b10:   if (pend_q != '1) pend_q <= pend_q + 1'b1;
                2'b01:   if (pend_q != '0) pend_q <= pend_q - 1'b1;
                default: pend_q <= pend_q;
            endcase
        end
    end

    assign pending_nz = (pend_q != '0);
    assign backlog_hi = (pend_q > PEND_W'(BACKLOG_MAX));

    // R10
    pend_inc_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && !served && pend_q != '1) |=> (pend_q == $past(pend_q) + PEND_W'(1)));

    // R10
    pend_dec_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (served && !tick && pend_q != '0) |=> (pend_q == $past(pend_q) - PEND_W'(1)));
endmodule

// File: rtl/rfsh_row_counter.sv
module rfsh_row_counter #(
    parameter int ROW_W = 10
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             adv,
    output logic [ROW_W-1:0] row_o
);
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            row_o <= '0;
        end else if (adv) begin
            row_o <= row_o + 1'b1;
        end
    end

    // R9
    row_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (adv && row_o == '1) |=> (row_o == '0));

    // R9
    row_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !adv |=> $stable(row_o));
endmodule

// File: rtl/rfsh_seq_fsm.sv
module rfsh_seq_fsm
    import dram_rfsh_pkg::*;
#(
    parameter int         PAUSE_CYC   = 10000,
    parameter int         INIT_CYCLES = 8,
    parameter int         T_SETUP     = 2,
    parameter int         T_ACTIVE    = 8,
    parameter int         T_PRECH     = 6,
    parameter rfsh_mode_e MODE        = RFM_CAS_FIRST
) (
    input  logic clk,
    input  logic rst_n,
    input  logic grant,
    input  logic pending_nz,
    output logic req_o,
    output logic own_o,
    output logic ras_n_o,
    output logic cas_n_o,
    output logic cycle_done_o,
    output logic ready_o
);
    localparam int PH_A   = (T_SETUP > T_ACTIVE) ? T_SETUP : T_ACTIVE;
    localparam int PH_B   = (PH_A > T_PRECH) ? PH_A : T_PRECH;
    localparam int PH_MAX = (PH_B > PAUSE_CYC) ? PH_B : PAUSE_CYC;
    localparam int CNT_W  = $clog2(PH_MAX + 1);
    localparam int INIT_W = $clog2(INIT_CYCLES + 1);

    seq_state_e         state_q, state_nxt;
    logic [CNT_W-1:0]   cnt_q;
    logic [INIT_W-1:0]  init_cnt_q;
    logic               ready_q;
    logic               phase_last;
    logic               timed;
    logic               init_left;

    assign init_left = !ready_q && (init_cnt_q < INIT_W'(INIT_CYCLES));

    always_comb begin
        timed = 1'b1;
        unique case (state_q)
            ST_PAUSE:  phase_last = (cnt_q == CNT_W'(PAUSE_CYC - 1));
            ST_SETUP:  phase_last = (cnt_q == CNT_W'(T_SETUP - 1));
            ST_ACTIVE: phase_last = (cnt_q == CNT_W'(T_ACTIVE - 1));
            ST_PRECH:  phase_last = (cnt_q == CNT_W'(T_PRECH - 1));
            default: begin
                phase_last = 1'b0;
                timed      = 1'b0;
            end
        endcase
    end

    always_comb begin
        state_nxt = state_q;
        unique case (state_q)
            ST_PAUSE:  if (phase_last) state_nxt = ST_REQ;
            ST_IDLE:   if (pending_nz) state_nxt = ST_REQ;
            ST_REQ:    if (grant)      state_nxt = ST_SETUP;
            ST_SETUP:  if (phase_last) state_nxt = ST_ACTIVE;
            ST_ACTIVE: if (phase_last) state_nxt = ST_PRECH;
            ST_PRECH:  if (phase_last) state_nxt = init_left ? ST_REQ : ST_IDLE;
            default:   state_nxt = ST_PAUSE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q    <= ST_PAUSE;
            cnt_q      <= '0;
            init_cnt_q <= '0;
            ready_q    <= 1'b0;
        end else begin
            state_q <= state_nxt;
            if (state_nxt != state_q) begin
                cnt_q <= '0;
            end else if (timed) begin
                cnt_q <= cnt_q + 1'b1;
            end
            if (cycle_done_o && !ready_q) begin
                init_cnt_q <= init_cnt_q + 1'b1;
            end
            if (state_q == ST_PRECH && phase_last && !init_left) begin
                ready_q <= 1'b1;
            end
        end
    end

    always_comb begin
        req_o        = (state_q == ST_REQ);
        own_o        = (state_q == ST_SETUP) || (state_q == ST_ACTIVE) || (state_q == ST_PRECH);
        ras_n_o      = (state_q != ST_ACTIVE);
        cas_n_o      = 1'b1;
        if (MODE == RFM_CAS_FIRST) begin
            cas_n_o = !((state_q == ST_SETUP) || (state_q == ST_ACTIVE));
        end
        cycle_done_o = (state_q == ST_ACTIVE) && phase_last;
        ready_o      = ready_q;
    end

    // R5
    req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_o && !grant) |=> req_o);

    // R5
    own_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_o && grant) |=> own_o);

    // R3
    ready_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ready_o |=> ready_o);

    // R3
    init_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ready_o) |-> (init_cnt_q == INIT_W'(INIT_CYCLES)));
endmodule

// File: rtl/dram_rfsh_seq.sv
module dram_rfsh_seq
    import dram_rfsh_pkg::*;
#(
    parameter int         PAUSE_CYC    = 10000,
    parameter int         INIT_CYCLES  = 8,
    parameter int         INTERVAL_CYC = 1560,
    parameter int         T_SETUP      = 2,
    parameter int         T_ACTIVE     = 8,
    parameter int         T_PRECH      = 6,
    parameter int         BACKLOG_MAX  = 8,
    parameter int         ROW_W        = 10,
    parameter rfsh_mode_e MODE         = RFM_CAS_FIRST
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             rfsh_grant_i,
    output logic             rfsh_req_o,
    output logic             bus_own_o,
    output logic             ready_o,
    output logic             backlog_hi_o,
    output logic             ras_n_o,
    output logic             cas_n_o,
    output logic             we_n_o,
    output logic [ROW_W:0]   addr_o
);
    localparam int PEND_W = $clog2(BACKLOG_MAX + 1) + 1;

    logic pending_nz;
    logic cycle_done;

    rfsh_seq_fsm #(
        .PAUSE_CYC  (PAUSE_CYC),
        .INIT_CYCLES(INIT_CYCLES),
        .T_SETUP    (T_SETUP),
        .T_ACTIVE   (T_ACTIVE),
        .T_PRECH    (T_PRECH),
        .MODE       (MODE)
    ) u_fsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .grant       (rfsh_grant_i),
        .pending_nz  (pending_nz),
        .req_o       (rfsh_req_o),
        .own_o       (bus_own_o),
        .ras_n_o     (ras_n_o),
        .cas_n_o     (cas_n_o),
        .cycle_done_o(cycle_done),
        .ready_o     (ready_o)
    );

    rfsh_interval_gen #(
        .INTERVAL_CYC(INTERVAL_CYC),
        .BACKLOG_MAX (BACKLOG_MAX),
        .PEND_W      (PEND_W)
    ) u_ivl (
        .clk       (clk),
        .rst_n     (rst_n),
        .en        (ready_o),
        .served    (cycle_done && ready_o),
        .pending_nz(pending_nz),
        .backlog_hi(backlog_hi_o)
    );

    assign we_n_o = 1'b1;

    generate
        if (MODE == RFM_ROW_ONLY) begin : g_row_only
            logic [ROW_W-1:0] row;

            rfsh_row_counter #(.ROW_W(ROW_W)) u_row (
                .clk  (clk),
                .rst_n(rst_n),
                .adv  (cycle_done),
                .row_o(row)
            );

            assign addr_o = bus_own_o ? {1'b0, row} : '0;

            // R8
            row_addr_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
                $fell(ras_n_o) |-> ($stable(addr_o) && cas_n_o));
        end else begin : g_cas_first
            assign addr_o = '0;

            // R6
            cas_lead_chk: assert property (@(posedge clk) disable iff (!rst_n)
                $fell(ras_n_o) |-> (!cas_n_o && $past(!cas_n_o)));

            // R6
            cas_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
                $rose(ras_n_o) |-> cas_n_o);
        end
    endgenerate

    // R5
    lines_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_own_o |-> (ras_n_o && cas_n_o && we_n_o && addr_o == '0));
endmodule

// File: tb/dram_rfsh_seq_tb.sv
module dram_rfsh_seq_tb;
    import dram_rfsh_pkg::*;

    localparam int PAUSE = 20;
    localparam int INITC = 8;
    localparam int IVL   = 40;
    localparam int TS    = 2;
    localparam int TA    = 4;
    localparam int TP    = 3;
    localparam int BMAX  = 3;
    localparam int RW    = 4;
    localparam int LEN   = TS + TA + TP;
    localparam int PSAT  = (1 << ($clog2(BMAX + 1) + 1)) - 1;
    localparam int ROWS  = 1 << RW;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic grant = 1'b0;
    always #4 clk = ~clk;

    logic        a_req, a_own, a_rdy, a_hi, a_ras, a_cas, a_we;
    logic [RW:0] a_addr;
    logic        b_req, b_own, b_rdy, b_hi, b_ras, b_cas, b_we;
    logic [RW:0] b_addr;

    dram_rfsh_seq #(.PAUSE_CYC(PAUSE), .INIT_CYCLES(INITC), .INTERVAL_CYC(IVL),
        .T_SETUP(TS), .T_ACTIVE(TA), .T_PRECH(TP), .BACKLOG_MAX(BMAX),
        .ROW_W(RW), .MODE(RFM_CAS_FIRST)) u_dut (
        .clk(clk), .rst_n(rst_n), .rfsh_grant_i(grant), .rfsh_req_o(a_req),
        .bus_own_o(a_own), .ready_o(a_rdy), .backlog_hi_o(a_hi), .ras_n_o(a_ras),
        .cas_n_o(a_cas), .we_n_o(a_we), .addr_o(a_addr));

    dram_rfsh_seq #(.PAUSE_CYC(PAUSE), .INIT_CYCLES(INITC), .INTERVAL_CYC(IVL),
        .T_SETUP(TS), .T_ACTIVE(TA), .T_PRECH(TP), .BACKLOG_MAX(BMAX),
        .ROW_W(RW), .MODE(RFM_ROW_ONLY)) u_dut_row (
        .clk(clk), .rst_n(rst_n), .rfsh_grant_i(grant), .rfsh_req_o(b_req),
        .bus_own_o(b_own), .ready_o(b_rdy), .backlog_hi_o(b_hi), .ras_n_o(b_ras),
        .cas_n_o(b_cas), .we_n_o(b_we), .addr_o(b_addr));

    int n_cmp = 0;
    int n_bad = 0;
    bit finished = 1'b0;

    task automatic chk(input string tag, input int act, input int exp);
        n_cmp++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
        end
    endtask

    // behavioural reference: mode 0 pause, 1 nothing owed, 2 asking, 3 in a cycle
    int m_mode, m_pause_left, m_pos, m_inits, m_tick, m_pend, m_row;
    bit m_ready;

    always @(posedge clk) begin
        if (!rst_n) begin
            m_mode = 0; m_pause_left = PAUSE; m_pos = 0; m_inits = 0;
            m_tick = 0; m_pend = 0; m_row = 0; m_ready = 1'b0;
        end else begin
            bit tick, done, old_ready;
            old_ready = m_ready;
            tick = old_ready && (m_tick == IVL - 1);
            m_tick = (!old_ready || tick) ? 0 : m_tick + 1;
            done = (m_mode == 3) && (m_pos == TS + TA - 1);
            if (tick && !(done && old_ready)) m_pend = (m_pend == PSAT) ? PSAT : m_pend + 1;
            else if (!tick && done && old_ready && m_pend > 0) m_pend = m_pend - 1;
            case (m_mode)
                0: if (m_pause_left == 1) m_mode = 2; else m_pause_left--;
                1: if (m_pend_before_nz) m_mode = 2;
                2: if (grant) begin m_mode = 3; m_pos = 0; end
                default: begin
                    if (m_pos == LEN - 1) begin
                        if (!old_ready && m_inits < INITC) m_mode = 2;
                        else begin m_ready = 1'b1; m_mode = 1; end
                    end else m_pos++;
                end
            endcase
            if (done) begin
                if (!old_ready) m_inits++;
                m_row = (m_row + 1) % ROWS;
            end
            m_pend_before_nz = (m_pend != 0);
        end
    end
    bit m_pend_before_nz = 1'b0;

    int  edges = 0;
    int  first_req = -1;
    int  ras_falls = 0;
    bit  prev_a_ras = 1'b1;
    bit  rdy_seen = 1'b0;
    bit  hi_seen = 1'b0;
    bit  wrap_seen = 1'b0;
    int  prev_row = -1;

    always @(posedge clk) if (rst_n) edges++;

    always @(negedge clk) begin
        if (rst_n && !finished) begin
            bit in_act;
            int e_addr;
            in_act = (m_mode == 3) && (m_pos >= TS) && (m_pos < TS + TA);
            e_addr = (m_mode == 3) ? m_row : 0;
            chk("R5 req A", a_req, m_mode == 2);
            chk("R5 own A", a_own, m_mode == 3);
            chk("R3 ready A", a_rdy, m_ready);
            chk("R11 backlog_hi A", a_hi, m_pend > BMAX);
            chk("R6 ras_n A", a_ras, !in_act);
            chk("R6 cas_n A", a_cas, !((m_mode == 3) && (m_pos < TS + TA)));
            chk("R7 we_n A", a_we, 1);
            chk("R5 addr A", a_addr, 0);
            chk("R10 req B", b_req, m_mode == 2);
            chk("R5 own B", b_own, m_mode == 3);
            chk("R3 ready B", b_rdy, m_ready);
            chk("R11 backlog_hi B", b_hi, m_pend > BMAX);
            chk("R8 ras_n B", b_ras, !in_act);
            chk("R8 cas_n B", b_cas, 1);
            chk("R7 we_n B", b_we, 1);
            chk("R9 addr B", b_addr, e_addr);
            if (a_req && first_req < 0) first_req = edges;
            if (prev_a_ras && !a_ras && !a_rdy) ras_falls++;
            prev_a_ras = a_ras;
            if (a_rdy && !rdy_seen) begin
                rdy_seen = 1'b1;
                chk("R3 wake-up cycle count", ras_falls, INITC);
                chk("R4 ready edge", edges, PAUSE + INITC * (LEN + 1));
            end
            if (a_hi) hi_seen = 1'b1;
            if (b_own && !b_ras) begin
                if (prev_row == ROWS - 1 && b_addr == 0) wrap_seen = 1'b1;
                prev_row = int'(b_addr);
            end
        end
    end

    task automatic finish_run();
        finished = 1'b1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    endtask

    initial begin
        repeat (5) @(negedge clk);
        // R1 reset state
        chk("R1 ras_n", a_ras, 1); chk("R1 cas_n", a_cas, 1);
        chk("R1 we_n", a_we, 1); chk("R1 req", a_req, 0);
        chk("R1 ready", a_rdy, 0); chk("R1 own", b_own, 0);
        chk("R1 addr", b_addr, 0); chk("R1 backlog", a_hi, 0);
        grant = 1'b1;
        rst_n = 1'b1;
        repeat (500) @(negedge clk);
        chk("R2 first request edge", first_req, PAUSE);
        grant = 1'b0;
        repeat (200) @(negedge clk);
        for (int i = 0; i < 300; i++) begin
            grant = (i % 3) != 0;
            @(negedge clk);
        end
        grant = 1'b1;
        repeat (700) @(negedge clk);
        chk("R11 backlog flag raised", hi_seen, 1);
        chk("R9 row counter wrapped", wrap_seen, 1);
        chk("R10 backlog drained", a_hi, 0);
        finish_run();
    end

    initial begin
        repeat (20000) @(posedge clk);
        n_cmp++;
        n_bad++;
        $display("FAIL watchdog actual=timeout expected=finish");
        finish_run();
    end
endmodule